// File: doc/BRIEF.md
# Event Timer Main Counter and Global Register Block

This block is the shared front end of a multi-channel event-timer peripheral. It holds the 64-bit main counter and the global configuration, and it answers a 32-bit register port. It advances the counter on a tick-enable strobe while the global enable is set. It sends the live count, the global enable and the legacy-route bit to every timer channel. It decodes the per-channel register windows and passes accesses to the addressed channel.

Software reaches every 64-bit quantity as two 32-bit words, low word first in address. A read-only capability word tells software four things: a fixed identity, that the counter is 64 bits, that legacy routing is possible, and how many channels exist. The next word gives the tick period in femtoseconds. Setting the global enable sends a one-cycle arm command to every channel whose comparator is not all ones. Clearing it freezes the counter and sends a one-cycle disarm command to every channel. The channels then deassert their interrupts.

Top module: `evt_timer_core`

## Requirements
- R1: After reset the main counter is zero, the global enable and the legacy-route bit are clear, and no arm or disarm command is active.
- R2: Offset 0x000 reads 0x8086A001 with (NUM_TIMERS-1) ORed in at bit 8 (0x8086A201 for three channels). Offset 0x004 reads TICK_FS. Writes to either word change nothing.
- R3: In the configuration word at 0x010, only bit 0 (global enable) and bit 1 (legacy route) can be written. All other bits read as zero. Offset 0x014 reads zero and ignores writes.
- R4: On each clock with tick_en high and the global enable set, the counter rises by exactly one. With tick_en low it holds.
- R5: A write to 0x0F0 replaces only counter bits 31:0, and a write to 0x0F4 replaces only bits 63:32. A counter write in the same cycle as a tick takes precedence over the increment.
- R6: The counter wraps from all ones to zero.
- R7: A read of either counter word returns the count held in the cycle of the access.
- R8: Offsets 0x100 + i*0x20 through 0x11F + i*0x20 belong to channel i. For i < NUM_TIMERS, an access asserts only chan_sel_o[i], with chan_word_o = address bits 4:2 and the channel's read word returned. For indices of NUM_TIMERS or more, no channel is selected, no write strobe is issued and the read returns zero.
- R9: A write that sets the global enable from clear pulses arm_o for one cycle, starting in the cycle after the write. The pulse is set for every channel whose chan_cmp_max_i bit was low in the write cycle.
- R10: A write that clears the global enable from set pulses disarm_o for all channels for one cycle, starting in the cycle after the write. From then on the counter does not advance.
- R11: cnt_o always equals the 64-bit count. glob_en_o and legacy_o show configuration bits 0 and 1.
- R12: Unmapped global offsets and offsets at 0x400 and above read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Counter advance strobe |
| acc_en | input | 1 | Register access valid |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 12 | Byte offset of the 32-bit word |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, combinational |
| chan_rdata_i | input | 32*NUM_TIMERS | Read word from each channel, channel 0 lowest |
| chan_cmp_max_i | input | NUM_TIMERS | Channel comparator is all ones |
| chan_sel_o | output | NUM_TIMERS | One-hot channel access select |
| chan_we_o | output | 1 | Write strobe to the selected channel |
| chan_word_o | output | 3 | Word index inside the channel window |
| chan_wdata_o | output | 32 | Write data to channels |
| cnt_o | output | 64 | Broadcast main count |
| glob_en_o | output | 1 | Broadcast global enable |
| legacy_o | output | 1 | Legacy-route configuration bit |
| arm_o | output | NUM_TIMERS | One-cycle re-arm commands |
| disarm_o | output | NUM_TIMERS | One-cycle disarm commands |

## Verification
The checker runs on every cycle. It covers the +1 step per enabled tick, including the wrap, and the frozen count while disabled. It covers the timing and channel masks of the arm and disarm pulses, which can only appear on an enable edge, and that at most one channel is selected. The bench scenarios cover the read-side behaviour: the capability value, the masked configuration write, half-word counter replacement and its priority over a tick, decode of windows past the last channel, and zero reads from unmapped offsets.

// File: rtl/evt_timer_pkg.sv
// Shared constants and types for the event-timer global block.
package evt_timer_pkg;
    localparam int ADDR_W      = 12;
    localparam int DATA_W      = 32;
    localparam int CNT_W       = 64;
    localparam int WORD_SEL_W  = 3;
    localparam int STRIDE_LG   = 5;

    localparam logic [ADDR_W-1:0] OFS_CAP_LO = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_CAP_HI = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_CFG_LO = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_CFG_HI = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_CNT_LO = 12'h0F0;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI = 12'h0F4;
    localparam logic [ADDR_W-1:0] CHAN_FIRST = 12'h100;
    localparam logic [ADDR_W-1:0] CHAN_LAST  = 12'h3FF;

    localparam int CFG_W       = 2;
    localparam int CFG_EN_BIT  = 0;
    localparam int CFG_LEG_BIT = 1;
    localparam logic [CFG_W-1:0] CFG_WR_MASK = 2'b11;

    localparam logic [DATA_W-1:0] IDENT_WORD    = 32'h8086_A001;
    localparam int                CAP_COUNT_LSB = 8;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CAP_LO,
        SEL_CAP_HI,
        SEL_CFG_LO,
        SEL_CFG_HI,
        SEL_CNT_LO,
        SEL_CNT_HI,
        SEL_CHAN
    } reg_sel_e;
endpackage

// File: rtl/evt_addr_decode.sv
// Address decoder: classifies a register offset as a global register, a
// channel window, or unmapped. Purely combinational. Assumes the channel
// windows begin on a 32-byte boundary.
module evt_addr_decode
    import evt_timer_pkg::*;
#(
    parameter int NUM_TIMERS = 3
) (
    input  logic [ADDR_W-1:0]     addr,
    output reg_sel_e              sel,
    output logic [NUM_TIMERS-1:0] chan_hit,
    output logic [WORD_SEL_W-1:0] word
);
    logic              in_win;
    logic [ADDR_W-1:0] win_idx;

    assign in_win  = (addr >= CHAN_FIRST) && (addr <= CHAN_LAST);
    assign win_idx = ADDR_W'(addr - CHAN_FIRST) >> STRIDE_LG;
    assign word    = addr[STRIDE_LG-1:2];

    // One comparator per implemented channel; higher indices match nothing.
    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_hit
        assign chan_hit[i] = in_win && (win_idx == ADDR_W'(i));
    end

    // Classify the offset into a register selector.
    always_comb begin
        sel = SEL_NONE;
        if (|chan_hit)                sel = SEL_CHAN;
        else if (addr == OFS_CAP_LO)  sel = SEL_CAP_LO;
        else if (addr == OFS_CAP_HI)  sel = SEL_CAP_HI;
        else if (addr == OFS_CFG_LO)  sel = SEL_CFG_LO;
        else if (addr == OFS_CFG_HI)  sel = SEL_CFG_HI;
        else if (addr == OFS_CNT_LO)  sel = SEL_CNT_LO;
        else if (addr == OFS_CNT_HI)  sel = SEL_CNT_HI;
    end
endmodule

// File: rtl/evt_main_counter.sv
// Main counter: a free-running 64-bit up counter that software can load one
// 32-bit half at a time. A load takes priority over an increment in the same
// cycle. The counter wraps naturally.
module evt_main_counter
    import evt_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic [DATA_W-1:0] ld_val,
    output logic [CNT_W-1:0]  count
);
    localparam int HALF = CNT_W / 2;

    // Load the addressed halves, otherwise step on an enabled tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (ld_lo || ld_hi) begin
            if (ld_lo) count[HALF-1:0]     <= ld_val;
            if (ld_hi) count[CNT_W-1:HALF] <= ld_val;
        end else if (run && tick) begin
            count <= count + CNT_W'(1);
        end
    end
endmodule

// File: rtl/evt_enable_sequencer.sv
// Enable-edge sequencer: watches the global enable, current versus next.
// On a rising edge it issues a one-cycle arm command to every channel whose
// comparator is not all ones. On a falling edge it issues a one-cycle
// disarm command to all channels.
module evt_enable_sequencer #(
    parameter int NUM_TIMERS = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en_cur,
    input  logic                  en_next,
    input  logic [NUM_TIMERS-1:0] cmp_max,
    output logic [NUM_TIMERS-1:0] arm,
    output logic [NUM_TIMERS-1:0] disarm
);
    logic rise;
    logic fall;

    assign rise = en_next && !en_cur;
    assign fall = en_cur && !en_next;

    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_chan
        logic arm_q;
        logic dis_q;

        // Register this channel's command for the edge just written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                arm_q <= 1'b0;
                dis_q <= 1'b0;
            end else begin
                arm_q <= rise && !cmp_max[i];
                dis_q <= fall;
            end
        end

        assign arm[i]    = arm_q;
        assign disarm[i] = dis_q;
    end
endmodule

// File: rtl/evt_timer_core.sv
// Event-timer global block: holds the register port, the capability words,
// the configuration, the main counter and the channel fan-out. Assumes
// 32-bit word accesses only. Channel registers live outside this block.
module evt_timer_core
    import evt_timer_pkg::*;
#(
    parameter int          NUM_TIMERS = 3,
    parameter logic [31:0] TICK_FS    = 32'd10_000_000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         tick_en,
    input  logic                         acc_en,
    input  logic                         acc_we,
    input  logic [ADDR_W-1:0]            acc_addr,
    input  logic [DATA_W-1:0]            acc_wdata,
    output logic [DATA_W-1:0]            acc_rdata,
    input  logic [DATA_W*NUM_TIMERS-1:0] chan_rdata_i,
    input  logic [NUM_TIMERS-1:0]        chan_cmp_max_i,
    output logic [NUM_TIMERS-1:0]        chan_sel_o,
    output logic                         chan_we_o,
    output logic [WORD_SEL_W-1:0]        chan_word_o,
    output logic [DATA_W-1:0]            chan_wdata_o,
    output logic [CNT_W-1:0]             cnt_o,
    output logic                         glob_en_o,
    output logic                         legacy_o,
    output logic [NUM_TIMERS-1:0]        arm_o,
    output logic [NUM_TIMERS-1:0]        disarm_o
);
    localparam logic [DATA_W-1:0] CAP_LO =
        IDENT_WORD | (DATA_W'(NUM_TIMERS - 1) << CAP_COUNT_LSB);
    localparam logic [DATA_W-1:0] CAP_HI = TICK_FS;

    reg_sel_e               sel;
    logic [NUM_TIMERS-1:0]  chan_hit;
    logic [CFG_W-1:0]       cfg_q;
    logic [CFG_W-1:0]       cfg_d;
    logic                   wr;
    logic [DATA_W-1:0]      chan_rd;

    assign wr = acc_en && acc_we;

    evt_addr_decode #(.NUM_TIMERS(NUM_TIMERS)) u_dec (
        .addr     (acc_addr),
        .sel      (sel),
        .chan_hit (chan_hit),
        .word     (chan_word_o)
    );

    // Next configuration: merge only the writable bits.
    always_comb begin
        cfg_d = cfg_q;
        if (wr && sel == SEL_CFG_LO)
            cfg_d = (acc_wdata[CFG_W-1:0] & CFG_WR_MASK) | (cfg_q & ~CFG_WR_MASK);
    end

    // Configuration register.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    evt_main_counter u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (cfg_q[CFG_EN_BIT]),
        .tick   (tick_en),
        .ld_lo  (wr && sel == SEL_CNT_LO),
        .ld_hi  (wr && sel == SEL_CNT_HI),
        .ld_val (acc_wdata),
        .count  (cnt_o)
    );

    evt_enable_sequencer #(.NUM_TIMERS(NUM_TIMERS)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_cur  (cfg_q[CFG_EN_BIT]),
        .en_next (cfg_d[CFG_EN_BIT]),
        .cmp_max (chan_cmp_max_i),
        .arm     (arm_o),
        .disarm  (disarm_o)
    );

    // Select the read word of the addressed channel.
    always_comb begin
        chan_rd = '0;
        for (int i = 0; i < NUM_TIMERS; i++)
            if (chan_hit[i]) chan_rd = chan_rdata_i[i*DATA_W +: DATA_W];
    end

    // Register read multiplexer.
    always_comb begin
        case (sel)
            SEL_CAP_LO: acc_rdata = CAP_LO;
            SEL_CAP_HI: acc_rdata = CAP_HI;
            SEL_CFG_LO: acc_rdata = DATA_W'(cfg_q);
            SEL_CNT_LO: acc_rdata = cnt_o[DATA_W-1:0];
            SEL_CNT_HI: acc_rdata = cnt_o[CNT_W-1:DATA_W];
            SEL_CHAN:   acc_rdata = chan_rd;
            default:    acc_rdata = '0;
        endcase
    end

    assign chan_sel_o   = acc_en ? chan_hit : '0;
    assign chan_we_o    = acc_we && |chan_sel_o;
    assign chan_wdata_o = acc_wdata;
    assign glob_en_o    = cfg_q[CFG_EN_BIT];
    assign legacy_o     = cfg_q[CFG_LEG_BIT];
endmodule

// File: rtl/evt_timer_core_chk.sv
// Property checker for evt_timer_core. It sees only the ports of the block.
module evt_timer_core_chk
    import evt_timer_pkg::*;
#(
    parameter int NUM_TIMERS = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  tick_en,
    input logic                  acc_en,
    input logic                  acc_we,
    input logic [ADDR_W-1:0]     acc_addr,
    input logic [NUM_TIMERS-1:0] chan_cmp_max_i,
    input logic [NUM_TIMERS-1:0] chan_sel_o,
    input logic [CNT_W-1:0]      cnt_o,
    input logic                  glob_en_o,
    input logic [NUM_TIMERS-1:0] arm_o,
    input logic [NUM_TIMERS-1:0] disarm_o
);
    logic cnt_wr;
    assign cnt_wr = acc_en && acc_we &&
                    (acc_addr == OFS_CNT_LO || acc_addr == OFS_CNT_HI);

    assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        glob_en_o && tick_en && !cnt_wr |=> cnt_o == $past(cnt_o) + CNT_W'(1));

    assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        glob_en_o && tick_en && !cnt_wr && (&cnt_o) |=> cnt_o == '0);

    assert_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en_o && !cnt_wr |=> $stable(cnt_o));

    assert_arm_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(glob_en_o) |-> arm_o == ~$past(chan_cmp_max_i));

    assert_arm_only_on_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(glob_en_o) |-> arm_o == '0);

    assert_disarm_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(glob_en_o) |-> &disarm_o);

    assert_disarm_only_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(glob_en_o) |-> disarm_o == '0);

    assert_one_channel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_sel_o));
endmodule

bind evt_timer_core evt_timer_core_chk #(.NUM_TIMERS(NUM_TIMERS)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .tick_en        (tick_en),
    .acc_en         (acc_en),
    .acc_we         (acc_we),
    .acc_addr       (acc_addr),
    .chan_cmp_max_i (chan_cmp_max_i),
    .chan_sel_o     (chan_sel_o),
    .cnt_o          (cnt_o),
    .glob_en_o      (glob_en_o),
    .arm_o          (arm_o),
    .disarm_o       (disarm_o)
);

// File: tb/test_evt_timer_core.sv
`timescale 1ns/1ps
module test_evt_timer_core;
    localparam int NT = 3;
    localparam int NV = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_en = 1'b0;
    logic          acc_en = 1'b0;
    logic          acc_we = 1'b0;
    logic [11:0]   acc_addr = '0;
    logic [31:0]   acc_wdata = '0;
    logic [31:0]   acc_rdata;
    logic [32*NT-1:0] chan_rdata = {32'hC0DE0002, 32'hC0DE0001, 32'hC0DE0000};
    logic [NT-1:0] cmp_max = '0;
    logic [NT-1:0] chan_sel;
    logic          chan_we;
    logic [2:0]    chan_word;
    logic [31:0]   chan_wdata;
    logic [63:0]   cnt;
    logic          glob_en;
    logic          legacy;
    logic [NT-1:0] arm;
    logic [NT-1:0] disarm;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] rd;

    always #4 clk = ~clk;

    evt_timer_core #(.NUM_TIMERS(NT)) i_evt_timer_core (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .acc_en(acc_en), .acc_we(acc_we), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .chan_rdata_i(chan_rdata), .chan_cmp_max_i(cmp_max),
        .chan_sel_o(chan_sel), .chan_we_o(chan_we), .chan_word_o(chan_word),
        .chan_wdata_o(chan_wdata), .cnt_o(cnt), .glob_en_o(glob_en),
        .legacy_o(legacy), .arm_o(arm), .disarm_o(disarm)
    );

    // {req number, write, address, write data or expected read}
    localparam logic [48:0] VECS [0:NV-1] = '{
        {4'd2,  1'b0, 12'h000, 32'h8086A201},
        {4'd2,  1'b0, 12'h004, 32'h00989680},
        {4'd2,  1'b1, 12'h000, 32'hFFFFFFFF},
        {4'd2,  1'b0, 12'h000, 32'h8086A201},
        {4'd2,  1'b1, 12'h004, 32'h00000000},
        {4'd2,  1'b0, 12'h004, 32'h00989680},
        {4'd3,  1'b1, 12'h010, 32'hFFFFFFFC},
        {4'd3,  1'b0, 12'h010, 32'h00000000},
        {4'd3,  1'b1, 12'h014, 32'hFFFFFFFF},
        {4'd3,  1'b0, 12'h014, 32'h00000000},
        {4'd5,  1'b1, 12'h0F0, 32'h12345678},
        {4'd5,  1'b0, 12'h0F0, 32'h12345678},
        {4'd5,  1'b0, 12'h0F4, 32'h00000000},
        {4'd5,  1'b1, 12'h0F4, 32'hCAFEBABE},
        {4'd5,  1'b0, 12'h0F4, 32'hCAFEBABE},
        {4'd5,  1'b0, 12'h0F0, 32'h12345678},
        {4'd12, 1'b0, 12'h020, 32'h00000000},
        {4'd8,  1'b0, 12'h160, 32'h00000000},
        {4'd8,  1'b0, 12'h120, 32'hC0DE0001},
        {4'd8,  1'b0, 12'h148, 32'hC0DE0002},
        {4'd3,  1'b1, 12'h010, 32'h00000002},
        {4'd3,  1'b0, 12'h010, 32'h00000002},
        {4'd8,  1'b0, 12'h3FC, 32'h00000000},
        {4'd12, 1'b0, 12'h400, 32'h00000000}
    };

    function automatic string req_name(input logic [3:0] n);
        case (n)
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd5:    return "R5";
            4'd8:    return "R8";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b1; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_en = 1'b0; acc_we = 1'b0;
    endtask

    task automatic do_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b0; acc_addr = a;
        #1 d = acc_rdata;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        check("R1", cnt, 64'd0);
        check("R1", {62'd0, glob_en, legacy}, 64'd0);
        check("R1", {58'd0, arm, disarm}, 64'd0);

        // Table walk with ticks held low so the count is static.
        for (int i = 0; i < NV; i++) begin
            if (VECS[i][44]) begin
                do_write(VECS[i][43:32], VECS[i][31:0]);
            end else begin
                do_read(VECS[i][43:32], rd);
                check(req_name(VECS[i][48:45]), {32'd0, rd}, {32'd0, VECS[i][31:0]});
            end
        end

        // R8: channel strobes, in range and beyond the last channel
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b1; acc_addr = 12'h148;
        #1 check("R8", {59'd0, chan_sel, chan_word, chan_we}, {59'd0, 3'b100, 3'd2, 1'b1});
        acc_addr = 12'h160;
        #1 check("R8", {60'd0, chan_sel, chan_we}, 64'd0);
        @(negedge clk) acc_en = 1'b0; acc_we = 1'b0;

        // R9: enable rise arms channels whose comparator is not all ones
        cmp_max = 3'b010;
        do_write(12'h010, 32'h3);
        check("R9", {61'd0, arm}, {61'd0, 3'b101});
        check("R11", {62'd0, glob_en, legacy}, {62'd0, 2'b11});
        @(negedge clk);
        check("R9", {61'd0, arm}, 64'd0);
        check("R4", cnt, 64'hCAFEBABE_12345678);

        // R4: five enabled ticks
        tick_en = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk) tick_en = 1'b0;
        do_read(12'h0F0, rd);
        check("R4", {32'd0, rd}, 64'h1234567D);
        check("R11", cnt, 64'hCAFEBABE_1234567D);

        // R7: read sees the value of the current cycle
        @(negedge clk);
        tick_en = 1'b1; acc_en = 1'b1; acc_we = 1'b0; acc_addr = 12'h0F0;
        #1 check("R7", {32'd0, acc_rdata}, 64'h1234567D);
        @(negedge clk);
        #1 check("R7", {32'd0, acc_rdata}, 64'h1234567E);
        tick_en = 1'b0;

        // R5: a load wins over a tick in the same cycle
        @(negedge clk);
        tick_en = 1'b1; acc_we = 1'b1; acc_addr = 12'h0F0; acc_wdata = 32'h10;
        @(negedge clk);
        tick_en = 1'b0; acc_en = 1'b0; acc_we = 1'b0;
        do_read(12'h0F0, rd);
        check("R5", {32'd0, rd}, 64'h10);
        do_read(12'h0F4, rd);
        check("R5", {32'd0, rd}, 64'hCAFEBABE);

        // R6: wrap from all ones
        do_write(12'h0F0, 32'hFFFFFFFF);
        do_write(12'h0F4, 32'hFFFFFFFF);
        @(negedge clk) tick_en = 1'b1;
        @(negedge clk) tick_en = 1'b0;
        check("R6", cnt, 64'd0);

        // R10: enable fall disarms all and freezes the count
        do_write(12'h010, 32'h2);
        check("R10", {61'd0, disarm}, {61'd0, 3'b111});
        check("R10", {63'd0, glob_en}, 64'd0);
        @(negedge clk);
        check("R10", {61'd0, disarm}, 64'd0);
        tick_en = 1'b1;
        repeat (3) @(negedge clk);
        tick_en = 1'b0;
        check("R10", cnt, 64'd0);
        do_read(12'h010, rd);
        check("R3", {32'd0, rd}, 64'h2);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule